// File: doc/BRIEF.md
# Interrupt Latency Measurement Monitor

The monitor watches two single-bit signals from outside the clock domain: an interrupt request line, and a marker bit that the service routine raises on entry and lowers on exit. Each signal passes through its own synchronizer. Edges are then detected on the synchronized levels, so the gap between the two rising edges keeps its cycle count.

For every request, a latency counter starts when the request edge arrives. It counts without pause until the marker rises. The result goes into four statistics: the smallest latency, the largest latency, a 48-bit running sum, and a count of samples. Software forms the average from the sum and the count. The monitor also times each marker pulse and keeps the last and the longest handler duration.

A request edge that arrives while an earlier measurement still waits for its marker is counted as an overrun. It does not restart the measurement. All statistics can be read through an address/data read port, and a synchronous clear input restarts them.

Top module: `irq_latency_mon`

## Requirements
- R1: When the request and marker inputs rise k clock cycles apart, with the marker later, the latency sample is k. This holds because both inputs pass through synchronizers of equal depth (SYNC_STAGES, default 2).
- R2: If both rising edges are seen in the same cycle while no measurement is pending, a sample of 0 is recorded.
- R3: Address 0 reads the smallest latency sample since reset or clear. It reads all-ones while no sample exists.
- R4: Address 1 reads the largest latency sample since reset or clear. It reads 0 while no sample exists.
- R5: Each sample adds its value to a 48-bit total and adds one to a 32-bit iteration count. Address 2 reads total bits 31:0, address 3 reads total bits 47:32, and address 4 reads the iteration count.
- R6: The latency counter and the duration counter stop at all-ones (2^LAT_W-1 and 2^DUR_W-1) and never wrap. A saturated sample is recorded at that value.
- R7: A request rising edge seen while a measurement is pending adds one to the overrun count (address 5). The pending latency is still measured from the first edge. This also applies when the marker rises in that same cycle.
- R8: When the synchronized marker falls after having been high for N cycles, N (saturated) becomes the last duration (address 7). The longest duration (address 6) is updated if N is larger.
- R9: A marker pulse with no pending request records a duration, but no latency sample.
- R10: A clear pulse sets the minimum to all-ones and sets the maximum, total, iterations, overrun, longest duration and last duration to 0. A sample in that same cycle is dropped. A measurement in progress continues.
- R11: After reset every register reads as it does after a clear. Read data is zero-extended to DATA_W bits and follows rd_addr_i in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | 1 | Interrupt request line (asynchronous) |
| mark_i | input | 1 | Handler marker bit (asynchronous) |
| clr_i | input | 1 | Synchronous statistics clear |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | DATA_W (32) | Register read data |

## Verification
The hardest cases to reach are the overlaps, where the request and marker edges fall in the same cycle. One such case is a second request edge that lands while a measurement is pending. Another is a gap longer than the counter can hold. The bench places each edge on an exact clock by driving both inputs at falling edges with chosen offsets. It sweeps offsets 0 to 24 in a scrambled order so that the minimum and maximum move both up and down. It builds the overrun case by pulsing the request twice before the marker rises. It uses an 8-bit counter configuration so that saturation is reached within a few hundred cycles.

// File: rtl/ilm_pkg.sv
package ilm_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_MIN_LAT  = 3'd0;
  localparam logic [ADDR_W-1:0] A_MAX_LAT  = 3'd1;
  localparam logic [ADDR_W-1:0] A_TOT_LO   = 3'd2;
  localparam logic [ADDR_W-1:0] A_TOT_HI   = 3'd3;
  localparam logic [ADDR_W-1:0] A_ITER     = 3'd4;
  localparam logic [ADDR_W-1:0] A_OVERRUN  = 3'd5;
  localparam logic [ADDR_W-1:0] A_MAX_DUR  = 3'd6;
  localparam logic [ADDR_W-1:0] A_LAST_DUR = 3'd7;

  typedef enum logic {
    LT_IDLE = 1'b0,
    LT_WAIT = 1'b1
  } lat_state_e;
endpackage

// File: rtl/ilm_sync.sv
module ilm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain_q[s] <= 1'b0;
        end else begin
          if (s == 0) chain_q[s] <= d_i;
          else        chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ilm_edge.sv
module ilm_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/ilm_lat_track.sv
module ilm_lat_track
  import ilm_pkg::*;
#(
  parameter int LAT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             irq_rise_i,
  input  logic             mark_rise_i,
  output logic             waiting_o,
  output logic             smp_valid_o,
  output logic [LAT_W-1:0] smp_o
);
  localparam logic [LAT_W-1:0] LAT_SAT = '1;

  function automatic logic [LAT_W-1:0] lat_sat_inc(input logic [LAT_W-1:0] v);
    return (v == LAT_SAT) ? v : v + LAT_W'(1);
  endfunction

  lat_state_e      st_q;
  logic [LAT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= LT_IDLE;
      cnt_q <= '0;
    end else begin
      case (st_q)
        LT_IDLE: begin
          if (irq_rise_i && !mark_rise_i) begin
            st_q  <= LT_WAIT;
            cnt_q <= lat_sat_inc('0);
          end
        end
        default: begin
          if (mark_rise_i) st_q  <= LT_IDLE;
          else             cnt_q <= lat_sat_inc(cnt_q);
        end
      endcase
    end
  end

  assign waiting_o   = (st_q == LT_WAIT);
  assign smp_valid_o = waiting_o ? mark_rise_i : (irq_rise_i & mark_rise_i);
  assign smp_o       = waiting_o ? cnt_q : '0;
endmodule

// File: rtl/ilm_dur_track.sv
module ilm_dur_track #(
  parameter int DUR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mark_lvl_i,
  input  logic             mark_rise_i,
  output logic             done_o,
  output logic [DUR_W-1:0] dur_o
);
  localparam logic [DUR_W-1:0] DUR_SAT = '1;

  function automatic logic [DUR_W-1:0] dur_sat_inc(input logic [DUR_W-1:0] v);
    return (v == DUR_SAT) ? v : v + DUR_W'(1);
  endfunction

  logic             busy_q;
  logic [DUR_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (mark_rise_i) begin
      busy_q <= 1'b1;
      cnt_q  <= dur_sat_inc('0);
    end else if (busy_q) begin
      if (mark_lvl_i) cnt_q  <= dur_sat_inc(cnt_q);
      else            busy_q <= 1'b0;
    end
  end

  assign done_o = busy_q & ~mark_lvl_i;
  assign dur_o  = cnt_q;
endmodule

// File: rtl/ilm_stats.sv
module ilm_stats #(
  parameter int LAT_W  = 16,
  parameter int DUR_W  = 16,
  parameter int TOT_W  = 48,
  parameter int ITER_W = 32,
  parameter int OVR_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              lat_valid_i,
  input  logic [LAT_W-1:0]  lat_i,
  input  logic              ovr_evt_i,
  input  logic              dur_valid_i,
  input  logic [DUR_W-1:0]  dur_i,
  output logic [LAT_W-1:0]  min_o,
  output logic [LAT_W-1:0]  max_o,
  output logic [TOT_W-1:0]  tot_o,
  output logic [ITER_W-1:0] iter_o,
  output logic [OVR_W-1:0]  ovr_o,
  output logic [DUR_W-1:0]  max_dur_o,
  output logic [DUR_W-1:0]  last_dur_o
);
  function automatic logic [LAT_W-1:0] pick_lo(input logic [LAT_W-1:0] a, input logic [LAT_W-1:0] b);
    return (b < a) ? b : a;
  endfunction

  function automatic logic [LAT_W-1:0] pick_hi(input logic [LAT_W-1:0] a, input logic [LAT_W-1:0] b);
    return (b > a) ? b : a;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      min_o <= '1; max_o <= '0; tot_o <= '0; iter_o <= '0; ovr_o <= '0;
      max_dur_o <= '0; last_dur_o <= '0;
    end else if (clr_i) begin
      min_o <= '1; max_o <= '0; tot_o <= '0; iter_o <= '0; ovr_o <= '0;
      max_dur_o <= '0; last_dur_o <= '0;
    end else begin
      if (lat_valid_i) begin
        min_o  <= pick_lo(min_o, lat_i);
        max_o  <= pick_hi(max_o, lat_i);
        tot_o  <= tot_o + TOT_W'(lat_i);
        iter_o <= iter_o + ITER_W'(1);
      end
      if (ovr_evt_i) ovr_o <= ovr_o + OVR_W'(1);
      if (dur_valid_i) begin
        last_dur_o <= dur_i;
        if (dur_i > max_dur_o) max_dur_o <= dur_i;
      end
    end
  end
endmodule

// File: rtl/irq_latency_mon.sv
module irq_latency_mon
  import ilm_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LAT_W       = 16,
  parameter int DUR_W       = 16,
  parameter int TOT_W       = 48,
  parameter int ITER_W      = 32,
  parameter int OVR_W       = 16,
  parameter int DATA_W      = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_i,
  input  logic              mark_i,
  input  logic              clr_i,
  input  logic [2:0]        rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int TOT_HI_W = TOT_W - DATA_W;

  logic [1:0] raw_in, sync_lvl, rise;
  assign raw_in = {mark_i, irq_i};

  generate
    for (genvar i = 0; i < 2; i++) begin : g_in
      ilm_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .d_i(raw_in[i]), .q_o(sync_lvl[i]));
      ilm_edge edge_i (
        .clk(clk), .rst_n(rst_n), .lvl_i(sync_lvl[i]), .rise_o(rise[i]));
    end
  endgenerate

  logic irq_rise, mark_rise, mark_lvl;
  assign irq_rise  = rise[0];
  assign mark_rise = rise[1];
  assign mark_lvl  = sync_lvl[1];

  logic             waiting, lat_valid, ovr_evt, dur_valid;
  logic [LAT_W-1:0] lat_smp;
  logic [DUR_W-1:0] dur_smp;

  ilm_lat_track #(.LAT_W(LAT_W)) lat_i (
    .clk(clk), .rst_n(rst_n), .irq_rise_i(irq_rise), .mark_rise_i(mark_rise),
    .waiting_o(waiting), .smp_valid_o(lat_valid), .smp_o(lat_smp));

  assign ovr_evt = waiting & irq_rise;

  ilm_dur_track #(.DUR_W(DUR_W)) dur_i (
    .clk(clk), .rst_n(rst_n), .mark_lvl_i(mark_lvl), .mark_rise_i(mark_rise),
    .done_o(dur_valid), .dur_o(dur_smp));

  logic [LAT_W-1:0]  min_q, max_q;
  logic [TOT_W-1:0]  tot_q;
  logic [ITER_W-1:0] iter_q;
  logic [OVR_W-1:0]  ovr_q;
  logic [DUR_W-1:0]  max_dur_q, last_dur_q;

  ilm_stats #(.LAT_W(LAT_W), .DUR_W(DUR_W), .TOT_W(TOT_W), .ITER_W(ITER_W), .OVR_W(OVR_W)) st_i (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i),
    .lat_valid_i(lat_valid), .lat_i(lat_smp), .ovr_evt_i(ovr_evt),
    .dur_valid_i(dur_valid), .dur_i(dur_smp),
    .min_o(min_q), .max_o(max_q), .tot_o(tot_q), .iter_o(iter_q), .ovr_o(ovr_q),
    .max_dur_o(max_dur_q), .last_dur_o(last_dur_q));

  logic [TOT_HI_W-1:0] tot_hi;
  assign tot_hi = tot_q[TOT_W-1:DATA_W];

  always_comb begin
    case (rd_addr_i)
      A_MIN_LAT:  rd_data_o = DATA_W'(min_q);
      A_MAX_LAT:  rd_data_o = DATA_W'(max_q);
      A_TOT_LO:   rd_data_o = tot_q[DATA_W-1:0];
      A_TOT_HI:   rd_data_o = DATA_W'(tot_hi);
      A_ITER:     rd_data_o = DATA_W'(iter_q);
      A_OVERRUN:  rd_data_o = DATA_W'(ovr_q);
      A_MAX_DUR:  rd_data_o = DATA_W'(max_dur_q);
      default:    rd_data_o = DATA_W'(last_dur_q);
    endcase
  end
endmodule

// File: rtl/ilm_chk.sv
module ilm_chk #(
  parameter int LAT_W  = 16,
  parameter int DUR_W  = 16,
  parameter int TOT_W  = 48,
  parameter int ITER_W = 32,
  parameter int OVR_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clr_i,
  input logic              irq_rise,
  input logic              mark_rise,
  input logic              waiting,
  input logic              lat_valid,
  input logic [LAT_W-1:0]  lat_smp,
  input logic [LAT_W-1:0]  min_q,
  input logic [LAT_W-1:0]  max_q,
  input logic [TOT_W-1:0]  tot_q,
  input logic [ITER_W-1:0] iter_q,
  input logic [OVR_W-1:0]  ovr_q,
  input logic [DUR_W-1:0]  max_dur_q,
  input logic [DUR_W-1:0]  last_dur_q
);
  // R2
  zero_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_rise && mark_rise && !waiting) |-> (lat_valid && lat_smp == '0));

  // R3
  min_le_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iter_q != '0) |-> (min_q <= max_q));

  // R5
  iter_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_valid && !clr_i) |=> (iter_q == $past(iter_q) + ITER_W'(1)));

  // R7
  ovr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_rise && waiting && !clr_i) |=> (ovr_q == $past(ovr_q) + OVR_W'(1)));

  // R8
  dur_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    max_dur_q >= last_dur_q);

  // R10
  clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (min_q == '1 && max_q == '0 && tot_q == '0 && iter_q == '0 && ovr_q == '0));
endmodule

bind irq_latency_mon ilm_chk #(
  .LAT_W(LAT_W), .DUR_W(DUR_W), .TOT_W(TOT_W), .ITER_W(ITER_W), .OVR_W(OVR_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .irq_rise(irq_rise), .mark_rise(mark_rise),
  .waiting(waiting), .lat_valid(lat_valid), .lat_smp(lat_smp), .min_q(min_q), .max_q(max_q),
  .tot_q(tot_q), .iter_q(iter_q), .ovr_q(ovr_q), .max_dur_q(max_dur_q), .last_dur_q(last_dur_q));

// File: tb/irq_latency_mon_tb_top.sv
`timescale 1ns/1ps
module irq_latency_mon_tb_top;
  localparam int LW = 8;
  localparam int DW = 8;
  localparam longint LSAT = (1 << LW) - 1;
  localparam longint DSAT = (1 << DW) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq_i = 1'b0, mark_i = 1'b0, clr_i = 1'b0;
  logic [2:0]  rd_addr_i = 3'd0;
  logic [31:0] rd_data_o;

  irq_latency_mon #(.LAT_W(LW), .DUR_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .mark_i(mark_i), .clr_i(clr_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o));

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  longint e_min, e_max, e_tot, e_iter, e_ovr, e_mdur, e_ldur;

  function automatic longint sat(input longint v, input longint lim);
    return (v > lim) ? lim : v;
  endfunction

  task automatic chk(input string req, input string what, input longint got, input longint exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic rd(input int a, output longint v);
    @(negedge clk);
    rd_addr_i = a[2:0];
    #1 v = rd_data_o;
  endtask

  task automatic model_clear();
    e_min = LSAT; e_max = 0; e_tot = 0; e_iter = 0; e_ovr = 0; e_mdur = 0; e_ldur = 0;
  endtask

  task automatic check_all(input string req);
    longint v;
    rd(0, v); chk(req, "R3 min", v, e_min);
    rd(1, v); chk(req, "R4 max", v, e_max);
    rd(2, v); chk(req, "R5 total lo", v, e_tot & 64'hFFFF_FFFF);
    rd(3, v); chk(req, "R5 total hi", v, (e_tot >> 32) & 64'hFFFF);
    rd(4, v); chk(req, "R5 iterations", v, e_iter);
    rd(5, v); chk(req, "R7 overrun", v, e_ovr);
    rd(6, v); chk(req, "R8 max dur", v, e_mdur);
    rd(7, v); chk(req, "R8 last dur", v, e_ldur);
  endtask

  task automatic model_lat(input longint k);
    longint s = sat(k, LSAT);
    if (s < e_min) e_min = s;
    if (s > e_max) e_max = s;
    e_tot += s; e_iter++;
  endtask

  task automatic model_dur(input longint d);
    e_ldur = sat(d, DSAT);
    if (e_ldur > e_mdur) e_mdur = e_ldur;
  endtask

  // request rises, marker rises k cycles later, stays high d cycles
  task automatic one_event(input int k, input int d);
    @(negedge clk);
    irq_i = 1'b1;
    if (k > 0) repeat (k) @(negedge clk);
    mark_i = 1'b1;
    repeat (d) @(negedge clk);
    mark_i = 1'b0; irq_i = 1'b0;
    repeat (6) @(negedge clk);
    model_lat(k); model_dur(d);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_all("R11 reset");

    // R1 R2 R3 R4 R5 R8: scrambled sweep of latency 0..24
    for (int i = 0; i < 25; i++) begin
      int k = (i * 11) % 25;
      int d = 1 + (i * 7) % 13;
      one_event(k, d);
      check_all(k == 0 ? "R2 zero latency" : "R1 sweep");
    end

    // R6: latency and duration saturation
    one_event(300, 3);
    check_all("R6 latency saturate");
    one_event(2, 300);
    check_all("R6 duration saturate");

    // R7: second request edge while pending, measured from first edge
    @(negedge clk); irq_i = 1'b1;
    repeat (3) @(negedge clk); irq_i = 1'b0;
    repeat (3) @(negedge clk); irq_i = 1'b1;
    repeat (4) @(negedge clk); mark_i = 1'b1;
    repeat (2) @(negedge clk); mark_i = 1'b0; irq_i = 1'b0;
    repeat (6) @(negedge clk);
    model_lat(10); model_dur(2); e_ovr++;
    check_all("R7 overrun");

    // R9: marker pulse with no pending request
    @(negedge clk); mark_i = 1'b1;
    repeat (5) @(negedge clk); mark_i = 1'b0;
    repeat (6) @(negedge clk);
    model_dur(5);
    check_all("R9 orphan marker");

    // R10: clear, then a fresh sample
    @(negedge clk); clr_i = 1'b1;
    @(negedge clk); clr_i = 1'b0;
    model_clear();
    check_all("R10 clear");
    one_event(7, 4);
    check_all("R10 after clear");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule